// File: doc/BRIEF.md
# Bunch Position Estimator

This block turns one stream of signed ADC samples into one beam position per bunch. The two pickup electrode responses share one channel. The second electrode is delayed by half a bunch period, so within each bunch slot the first half of the samples belongs to electrode A and the second half to electrode B. A bunch-start strobe marks sample zero of a slot. The block squares and sums the samples of each electrode window. It takes the root of the mean square as that electrode's amplitude. It then forms the normalized difference (A−B)/(A+B), scaled so that the full signed output range spans ±7.5 mm of displacement.

The mean, the root and the ratio are computed by one shared iterative divider and one iterative square-root unit. While they work, the accumulators already collect the next slot. A doublet mode shortens each electrode window to the overlap-free quarter. A minimum-intensity threshold suppresses positions computed from too little signal. A bunch start that arrives while the previous result is still being computed raises an overrun flag.

Top module: `pos_est_top`

## Requirements
- R1: Counting accepted samples (sampleValid high) from the cycle of bunchStart as index 0, indices 0..N−1 form window A and indices WIN_LEN..WIN_LEN+N−1 form window B, with WIN_LEN = 40 and N the window length.
- R2: rmsA and rmsB equal floor(sqrt(floor(S/N))), where S is the sum of squared signed samples of that window.
- R3: posOut is the 16-bit signed value trunc((A−B)·32768/(A+B)), rounded toward zero. The value +32768 saturates to 32767, so ±32768 LSB correspond to ±7.5 mm.
- R4: doubletMode, sampled in the bunchStart cycle, sets N = 10 for both windows of that slot; otherwise N = 40. Samples at indices N..39 are ignored.
- R5: Each completed slot produces exactly one single-cycle posValid pulse, with rmsA, rmsB, posOut and lowIntensity valid in that cycle.
- R6: If A+B is zero or below minSum, posOut is 0 and lowIntensity is 1 at posValid. Otherwise lowIntensity is 0.
- R7: Samples with index 80 or more, samples with sampleValid low, and all samples before the first bunchStart after reset are ignored.
- R8: A bunchStart while the compute engine is busy sets overrun to 1. A bunchStart while idle sets it to 0. overrun holds its value between strobes. The result in progress still completes.
- R9: After reset, posValid, overrun, lowIntensity, rmsA, rmsB and posOut are all 0.
- R10: A full window of −2048 samples produces an RMS of 2048 with no accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 12 | Signed two's-complement ADC sample |
| sampleValid | input | 1 | Sample on sampleIn is valid |
| bunchStart | input | 1 | Marks index 0 of a bunch slot |
| doubletMode | input | 1 | Selects the shortened windows for this slot |
| minSum | input | 13 | Minimum A+B below which the position is suppressed |
| rmsA | output | 12 | RMS amplitude of electrode A |
| rmsB | output | 12 | RMS amplitude of electrode B |
| posOut | output | 16 | Signed normalized position |
| posValid | output | 1 | One-cycle result strobe |
| lowIntensity | output | 1 | Position suppressed for low signal |
| overrun | output | 1 | Last bunchStart arrived while busy |

## Verification
The bench feeds slots with gaps in sampleValid and with large junk values after each window and in the doublet gap. A design that counted cycles instead of valid samples, or that let junk into a window, would report an inflated RMS. Equal, strongly unbalanced and one-sided amplitudes check sign, truncation and the +32768 clip. A design that wrapped at the clip would report a negative full-scale value. Full-scale negative samples check accumulator width and root range, all-zero and weak slots check the low-intensity path, and a strobe issued during computation checks the overrun flag and that the pending result is still delivered.

// File: rtl/pos_est_pkg.sv
package pos_est_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_MEANA, PH_ROOTA, PH_MEANB, PH_ROOTB, PH_CHECK, PH_RATIO
  } phase_t;

  typedef enum logic [1:0] {DS_SUMA, DS_SUMB, DS_RATIO} divSel_t;

  typedef struct packed {
    logic    accClr;
    logic    accEnA;
    logic    accEnB;
    logic    capture;
    logic    engDoublet;
    logic    divStart;
    divSel_t divSel;
    logic    sqrtStart;
    logic    latchMean;
    logic    latchRmsA;
    logic    latchRmsB;
    logic    latchPos;
    logic    writeLow;
  } ctrlStrobe_t;

endpackage

// File: rtl/pos_est_divider.sv
module pos_est_divider #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [W-1:0]     remReg, quotReg, dvsReg, dvdReg;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [W:0]       remShift;

  assign remShift = {remReg, quotReg[W-1]};
  assign quotient = quotReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg  <= '0;
      quotReg <= '0;
      dvsReg  <= '0;
      dvdReg  <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        remReg  <= '0;
        quotReg <= dividend;
        dvsReg  <= divisor;
        dvdReg  <= dividend;
        cnt     <= CNT_W'(W);
        busy    <= 1'b1;
      end else if (busy) begin
        if (remShift >= {1'b0, dvsReg}) begin
          remReg  <= W'(remShift - {1'b0, dvsReg});
          quotReg <= {quotReg[W-2:0], 1'b1};
        end else begin
          remReg  <= remShift[W-1:0];
          quotReg <= {quotReg[W-2:0], 1'b0};
        end
        cnt <= cnt - CNT_ONE;
        if (cnt == CNT_ONE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: quotient and remainder rebuild the dividend exactly
  p_div_exact_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((2*W)'(quotReg) * (2*W)'(dvsReg) + (2*W)'(remReg) == (2*W)'(dvdReg))
             && (remReg < dvsReg));

endmodule

// File: rtl/pos_est_isqrt.sv
module pos_est_isqrt #(
  parameter int RW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2*RW-1:0] radicand,
  output logic            done,
  output logic [RW-1:0]   root
);
  logic [2*RW-1:0] radReg;
  logic [RW-1:0]   rootReg, mask, trial;
  logic [2*RW-1:0] trialSq;
  logic            busy;

  assign trial   = rootReg | mask;
  assign trialSq = (2*RW)'(trial) * (2*RW)'(trial);
  assign root    = rootReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      radReg  <= '0;
      rootReg <= '0;
      mask    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        radReg  <= radicand;
        rootReg <= '0;
        mask    <= {1'b1, {(RW-1){1'b0}}};
        busy    <= 1'b1;
      end else if (busy) begin
        if (trialSq <= radReg) rootReg <= trial;
        mask <= mask >> 1;
        if (mask[0]) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: the root is the floor of the exact square root
  p_root_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((2*RW+2)'(rootReg) * (2*RW+2)'(rootReg) <= (2*RW+2)'(radReg))
             && (((2*RW+2)'(rootReg) + 1) * ((2*RW+2)'(rootReg) + 1) > (2*RW+2)'(radReg)));

endmodule

// File: rtl/pos_est_ctrl.sv
module pos_est_ctrl
  import pos_est_pkg::*;
#(
  parameter int WIN_LEN = 40,
  parameter int DBL_LEN = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        bunchStart,
  input  logic        doubletMode,
  input  logic        divDone,
  input  logic        sqrtDone,
  input  logic        lowSum,
  output ctrlStrobe_t strb,
  output logic        overrun
);
  localparam int SLOT  = 2 * WIN_LEN;
  localparam int IDX_W = $clog2(SLOT + 1);
  localparam logic [IDX_W-1:0] SLOT_C = IDX_W'(SLOT);
  localparam logic [IDX_W-1:0] WIN_C  = IDX_W'(WIN_LEN);
  localparam logic [IDX_W-1:0] DBL_C  = IDX_W'(DBL_LEN);
  localparam logic [IDX_W-1:0] ONE_C  = IDX_W'(1);

  logic [IDX_W-1:0] idxReg, curIdx, curLen, endB;
  logic             modeReg, curMode, take, inA, inB, lastB;
  logic             capReq, capMode, kick, engDbl;
  phase_t           phase;

  // window selection for the sample presented this cycle
  assign curIdx  = bunchStart ? '0 : idxReg;
  assign curMode = bunchStart ? doubletMode : modeReg;
  assign curLen  = curMode ? DBL_C : WIN_C;
  assign endB    = WIN_C + curLen;
  assign take    = sampleValid && (curIdx < SLOT_C);
  assign inA     = take && (curIdx < curLen);
  assign inB     = take && (curIdx >= WIN_C) && (curIdx < endB);
  assign lastB   = inB && (curIdx + ONE_C == endB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg  <= SLOT_C;
      modeReg <= 1'b0;
      capReq  <= 1'b0;
      capMode <= 1'b0;
    end else begin
      if (bunchStart) modeReg <= doubletMode;
      if (take)            idxReg <= curIdx + ONE_C;
      else if (bunchStart) idxReg <= '0;
      capReq  <= lastB;
      capMode <= curMode;
    end
  end

  // compute sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      kick    <= 1'b0;
      engDbl  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      kick <= 1'b0;
      if (bunchStart) overrun <= (phase != PH_IDLE);
      case (phase)
        PH_IDLE:  if (capReq)   begin phase <= PH_MEANA; kick <= 1'b1; engDbl <= capMode; end
        PH_MEANA: if (divDone)  begin phase <= PH_ROOTA; kick <= 1'b1; end
        PH_ROOTA: if (sqrtDone) begin phase <= PH_MEANB; kick <= 1'b1; end
        PH_MEANB: if (divDone)  begin phase <= PH_ROOTB; kick <= 1'b1; end
        PH_ROOTB: if (sqrtDone) phase <= PH_CHECK;
        PH_CHECK: if (lowSum) phase <= PH_IDLE;
                  else begin phase <= PH_RATIO; kick <= 1'b1; end
        PH_RATIO: if (divDone)  phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.accClr     = bunchStart;
    strb.accEnA     = inA;
    strb.accEnB     = inB;
    strb.capture    = capReq && (phase == PH_IDLE);
    strb.engDoublet = engDbl;
    strb.divStart   = kick && (phase == PH_MEANA || phase == PH_MEANB || phase == PH_RATIO);
    strb.divSel     = (phase == PH_MEANB) ? DS_SUMB :
                      (phase == PH_RATIO) ? DS_RATIO : DS_SUMA;
    strb.sqrtStart  = kick && (phase == PH_ROOTA || phase == PH_ROOTB);
    strb.latchMean  = divDone && (phase == PH_MEANA || phase == PH_MEANB);
    strb.latchRmsA  = sqrtDone && (phase == PH_ROOTA);
    strb.latchRmsB  = sqrtDone && (phase == PH_ROOTB);
    strb.latchPos   = divDone && (phase == PH_RATIO);
    strb.writeLow   = (phase == PH_CHECK) && lowSum;
  end

  // R8: a strobe arriving during computation is flagged
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bunchStart && phase != PH_IDLE) |=> overrun);

  // R7: the sample index never runs past the slot end
  p_idx_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    idxReg <= SLOT_C);

endmodule

// File: rtl/pos_est_datapath.sv
module pos_est_datapath
  import pos_est_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WIN_LEN  = 40,
  parameter int DBL_LEN  = 10,
  parameter int POS_W    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  ctrlStrobe_t                strb,
  input  logic [SAMPLE_W:0]          minSum,
  output logic                       divDone,
  output logic                       sqrtDone,
  output logic                       lowSum,
  output logic [SAMPLE_W-1:0]        rmsA,
  output logic [SAMPLE_W-1:0]        rmsB,
  output logic signed [POS_W-1:0]    posOut,
  output logic                       posValid,
  output logic                       lowIntensity
);
  localparam int SQ_W  = 2 * SAMPLE_W;
  localparam int ACC_W = SQ_W + $clog2(WIN_LEN + 1);
  localparam int RMS_W = SAMPLE_W;
  localparam logic [ACC_W-1:0] WIN_N  = ACC_W'(WIN_LEN);
  localparam logic [ACC_W-1:0] DBL_N  = ACC_W'(DBL_LEN);
  localparam logic [ACC_W-1:0] HALF_A = ACC_W'(2 ** (POS_W - 1));
  localparam logic [POS_W-1:0] HALF_P = POS_W'(2 ** (POS_W - 1));
  localparam logic [POS_W-1:0] MAX_P  = POS_W'(2 ** (POS_W - 1) - 1);

  logic signed [SQ_W-1:0]  sqS;
  logic [SQ_W-1:0]         sqU;
  logic [ACC_W-1:0]        accA, accB, sumA, sumB;
  logic [ACC_W-1:0]        divDvd, divDvs, divQuot;
  logic [2*RMS_W-1:0]      meanReg;
  logic [RMS_W-1:0]        rootOut, mag;
  logic [RMS_W:0]          rmsSum;
  logic                    negD;
  logic [POS_W-1:0]        qClip;

  assign sqS = sampleIn * sampleIn;
  assign sqU = unsigned'(sqS);

  // square-and-sum per electrode window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accA <= '0;
      accB <= '0;
      sumA <= '0;
      sumB <= '0;
    end else begin
      accA <= (strb.accClr ? '0 : accA) + (strb.accEnA ? ACC_W'(sqU) : '0);
      accB <= (strb.accClr ? '0 : accB) + (strb.accEnB ? ACC_W'(sqU) : '0);
      if (strb.capture) begin
        sumA <= accA;
        sumB <= accB;
      end
    end
  end

  assign rmsSum = {1'b0, rmsA} + {1'b0, rmsB};
  assign negD   = rmsB > rmsA;
  assign mag    = negD ? (rmsB - rmsA) : (rmsA - rmsB);
  assign lowSum = (rmsSum == '0) || (rmsSum < minSum);

  always_comb begin
    case (strb.divSel)
      DS_SUMB:  divDvd = sumB;
      DS_RATIO: divDvd = ACC_W'({mag, {(POS_W-1){1'b0}}});
      default:  divDvd = sumA;
    endcase
    if (strb.divSel == DS_RATIO) divDvs = ACC_W'(rmsSum);
    else                         divDvs = strb.engDoublet ? DBL_N : WIN_N;
  end

  pos_est_divider #(.W(ACC_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strb.divStart),
    .dividend (divDvd),
    .divisor  (divDvs),
    .done     (divDone),
    .quotient (divQuot)
  );

  pos_est_isqrt #(.RW(RMS_W)) u_sqrt (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strb.sqrtStart),
    .radicand (meanReg),
    .done     (sqrtDone),
    .root     (rootOut)
  );

  assign qClip = (divQuot > HALF_A) ? HALF_P : divQuot[POS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      meanReg      <= '0;
      rmsA         <= '0;
      rmsB         <= '0;
      posOut       <= '0;
      posValid     <= 1'b0;
      lowIntensity <= 1'b0;
    end else begin
      posValid <= 1'b0;
      if (strb.latchMean) meanReg <= divQuot[2*RMS_W-1:0];
      if (strb.latchRmsA) rmsA <= rootOut;
      if (strb.latchRmsB) rmsB <= rootOut;
      if (strb.writeLow) begin
        posOut       <= '0;
        lowIntensity <= 1'b1;
        posValid     <= 1'b1;
      end else if (strb.latchPos) begin
        posOut       <= negD ? -qClip : ((qClip == HALF_P) ? MAX_P : qClip);
        lowIntensity <= 1'b0;
        posValid     <= 1'b1;
      end
    end
  end

  // R10: without a clear the sums can only grow, so no wrap occurs
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accClr |=> (accA >= $past(accA)) && (accB >= $past(accB)));

  // R5: results are single-cycle strobes
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    posValid |=> !posValid);

  // R6: suppressed results read as zero position
  p_low_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (posValid && lowIntensity) |-> (posOut == '0));

  // R3: sign of the position follows the larger electrode
  p_pos_sign_r3: assert property (@(posedge clk) disable iff (!rstN)
    posValid |-> ((posOut > 0) -> (rmsA > rmsB)) && ((posOut < 0) -> (rmsA < rmsB)));

endmodule

// File: rtl/pos_est_top.sv
module pos_est_top
  import pos_est_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WIN_LEN  = 40,
  parameter int DBL_LEN  = 10,
  parameter int POS_W    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic                       bunchStart,
  input  logic                       doubletMode,
  input  logic [SAMPLE_W:0]          minSum,
  output logic [SAMPLE_W-1:0]        rmsA,
  output logic [SAMPLE_W-1:0]        rmsB,
  output logic signed [POS_W-1:0]    posOut,
  output logic                       posValid,
  output logic                       lowIntensity,
  output logic                       overrun
);
  ctrlStrobe_t strb;
  logic        divDone, sqrtDone, lowSum;

  pos_est_ctrl #(.WIN_LEN(WIN_LEN), .DBL_LEN(DBL_LEN)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .bunchStart  (bunchStart),
    .doubletMode (doubletMode),
    .divDone     (divDone),
    .sqrtDone    (sqrtDone),
    .lowSum      (lowSum),
    .strb        (strb),
    .overrun     (overrun)
  );

  pos_est_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .WIN_LEN  (WIN_LEN),
    .DBL_LEN  (DBL_LEN),
    .POS_W    (POS_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sampleIn     (sampleIn),
    .strb         (strb),
    .minSum       (minSum),
    .divDone      (divDone),
    .sqrtDone     (sqrtDone),
    .lowSum       (lowSum),
    .rmsA         (rmsA),
    .rmsB         (rmsB),
    .posOut       (posOut),
    .posValid     (posValid),
    .lowIntensity (lowIntensity)
  );

endmodule

// File: tb/pos_est_top_tb.sv
module pos_est_top_tb;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic signed [11:0] sampleIn = '0;
  logic               sampleValid = 1'b0;
  logic               bunchStart = 1'b0;
  logic               doubletMode = 1'b0;
  logic [12:0]        minSum = '0;
  logic [11:0]        rmsA, rmsB;
  logic signed [15:0] posOut;
  logic               posValid, lowIntensity, overrun;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  pos_est_top u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .bunchStart(bunchStart), .doubletMode(doubletMode), .minSum(minSum),
    .rmsA(rmsA), .rmsB(rmsB), .posOut(posOut), .posValid(posValid),
    .lowIntensity(lowIntensity), .overrun(overrun)
  );

  // pattern: 0 mixed amplitude, 1 all -2048, 2 all zero
  typedef struct packed {
    logic        dbl;
    logic [1:0]  pat;
    logic [11:0] ampA;
    logic [11:0] ampB;
    logic [12:0] minS;
    logic        expLow;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd0, 12'd1000, 12'd1000, 13'd0,   1'b0},
    '{1'b0, 2'd0, 12'd1500, 12'd500,  13'd0,   1'b0},
    '{1'b0, 2'd0, 12'd200,  12'd1800, 13'd0,   1'b0},
    '{1'b1, 2'd0, 12'd900,  12'd300,  13'd0,   1'b0},
    '{1'b0, 2'd0, 12'd2000, 12'd0,    13'd0,   1'b0},
    '{1'b0, 2'd0, 12'd50,   12'd40,   13'd200, 1'b1},
    '{1'b0, 2'd2, 12'd0,    12'd0,    13'd0,   1'b1},
    '{1'b0, 2'd1, 12'd0,    12'd0,    13'd0,   1'b0}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int amp, input int k, input int pat);
    if (pat == 1) return -2048;
    if (pat == 2) return 0;
    if (k % 2 == 1) return -amp;
    return amp - ((amp > 10) ? (k % 5) : 0);
  endfunction

  function automatic int sampleAt(input vec_t v, input int idx);
    int n = v.dbl ? 10 : 40;
    if (idx < n) return gen(int'(v.ampA), idx, int'(v.pat));
    if (idx >= 40 && idx < 40 + n) return gen(int'(v.ampB), idx - 40, int'(v.pat));
    return 1500;
  endfunction

  function automatic longint isq(input longint x);
    longint r = 0;
    for (int b = 15; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction

  function automatic longint rmsModel(input vec_t v, input int base);
    int n = v.dbl ? 10 : 40;
    longint s = 0;
    for (int k = 0; k < n; k++) begin
      longint x = sampleAt(v, base + k);
      s += x * x;
    end
    return isq(s / n);
  endfunction

  task automatic sendSlot(input vec_t v, input bit gaps);
    int acc = 0;
    int cyc = 0;
    while (acc < 86) begin
      @(negedge clk);
      bunchStart  = (cyc == 0);
      doubletMode = v.dbl;
      minSum      = v.minS;
      sampleValid = (cyc == 0) || !gaps || (cyc % 7 != 6);
      sampleIn    = sampleValid ? 12'(sampleAt(v, acc)) : 12'sd2047;
      if (sampleValid) acc++;
      cyc++;
    end
    @(negedge clk);
    bunchStart  = 1'b0;
    sampleValid = 1'b0;
    sampleIn    = '0;
  endtask

  task automatic collect(output int pulses, output longint ra, output longint rb,
                         output longint p, output longint lo);
    pulses = 0; ra = -1; rb = -1; p = -99999; lo = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (posValid) begin
        pulses++;
        ra = rmsA; rb = rmsB; p = posOut; lo = lowIntensity;
      end
    end
  endtask

  initial begin
    #750us;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int pulses;
    longint ra, rb, p, lo, ea, eb, ep, sum, mag, q;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 posValid", posValid, 0);
    check("R9 overrun", overrun, 0);
    check("R9 lowIntensity", lowIntensity, 0);
    check("R9 rmsA", rmsA, 0);
    check("R9 rmsB", rmsB, 0);
    check("R9 posOut", posOut, 0);

    // R7: samples before the first strobe are ignored
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleIn = 12'sd1234;
    end
    @(negedge clk);
    sampleValid = 1'b0;
    collect(pulses, ra, rb, p, lo);
    check("R7 no result before first strobe", pulses, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R10
    foreach (VECS[i]) begin
      sendSlot(VECS[i], 1'b1);
      collect(pulses, ra, rb, p, lo);
      ea  = rmsModel(VECS[i], 0);
      eb  = rmsModel(VECS[i], 40);
      sum = ea + eb;
      if (sum == 0 || sum < longint'(VECS[i].minS)) ep = 0;
      else begin
        mag = (ea >= eb) ? ea - eb : eb - ea;
        q = (mag << 15) / sum;
        ep = (ea >= eb) ? ((q > 32767) ? 32767 : q) : -((q > 32768) ? 32768 : q);
      end
      check("R5 one pulse per slot", pulses, 1);
      check("R2 R1 R7 rmsA", ra, ea);
      check("R2 R1 R7 rmsB", rb, eb);
      check("R3 R4 posOut", p, ep);
      check("R6 lowIntensity", lo, longint'(VECS[i].expLow));
      if (VECS[i].pat == 2'd1) check("R10 full-scale rms", ra, 2048);
    end

    // R8: strobe while busy
    sendSlot(VECS[1], 1'b0);
    @(negedge clk);
    bunchStart = 1'b1;
    @(negedge clk);
    bunchStart = 1'b0;
    check("R8 overrun set", overrun, 1);
    collect(pulses, ra, rb, p, lo);
    check("R8 pending result delivered", pulses, 1);
    check("R8 pending rmsA", ra, rmsModel(VECS[1], 0));
    check("R8 overrun held", overrun, 1);
    @(negedge clk);
    bunchStart = 1'b1;
    @(negedge clk);
    bunchStart = 1'b0;
    check("R8 overrun cleared when idle", overrun, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule